// File: doc/BRIEF.md
# Auto-Increment Control Register Bank

This block is the byte-wide register file that sits behind a peripheral's serial control port. A byte-level front end, which is outside this block, decodes the bus and hands over three things: a transaction-start flag, write bytes with a valid strobe, and read strobes. The first write byte of each transaction is taken as a pointer byte. Its top bit turns auto-increment on or off, and its low seven bits choose a register. Data bytes that follow are written to the chosen register. A read returns the chosen register.

When increment is off, every data byte and every read goes to the same register. When increment is on, the index steps by one after each byte, so consecutive registers can be moved in one block transfer. The bank holds a read-only identification register at index 01h and seven writable control registers at indices 02h to 08h. Each writable register has a fixed reset value and a set of reserved bits that always read as zero. All seven control registers drive parallel outputs to the core.

Top module: `ctl_regbank`

## Requirements
- R1: After reset the outputs hold these values: `pwr_q`=00h, `mode_q`=30h, `path_q`=00h, `ramp_q`=60h, `mute_q`=20h, `vol_a_q`=00h, `vol_b_q`=00h. The pointer index is 00h and increment is off.
- R2: The first `wr_valid` byte after a `txn_start` is a pointer byte. Bit 7 sets the increment flag and bits 6:0 set the index. When `txn_start` and `wr_valid` are high in the same cycle, that byte is the pointer byte. A pointer byte changes no register.
- R3: While the increment flag is 0, the index does not change across data write bytes or read strobes. Repeated writes and reads all go to the same register.
- R4: While the increment flag is 1, the index goes up by one after each data write byte and after each accepted read strobe.
- R5: Stepping past index 7Fh wraps the index to 00h. The increment flag stays set.
- R6: `rd_data` always shows the register at the current index, with no delay. Index 00h and indices 09h to 7Fh read 00h.
- R7: Index 01h reads the ID_CODE parameter (default C1h: ID nibble Ch, revision nibble 1h). Writes to 01h, 00h or 09h to 7Fh change no output. The index still steps as in R4.
- R8: The bits that can be written are `pwr_q` A3h, `mode_q` 3Fh, `path_q` F9h and `mute_q` 3Fh. In `ramp_q`, `vol_a_q` and `vol_b_q` all bits can be written. All other bits read 0 whatever is written to them.
- R9: A `txn_start` with no write byte after it leaves the index and flag unchanged. Reads that follow use the last pointer.
- R10: When `wr_valid` and `rd_strobe` are high in the same cycle, only the write is carried out. The index steps at most once.
- R11: A data write byte shows on its register's output in the cycle after the clock edge that takes it. Outputs change on no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Start of a new control-port transaction |
| wr_valid | input | 1 | `wr_byte` holds a byte from the host |
| wr_byte | input | 8 | Pointer byte or data byte |
| rd_strobe | input | 1 | Host has taken `rd_data`; advance if increment is on |
| rd_data | output | 8 | Contents of the register at the current index |
| pwr_q | output | 8 | Register 02h, power control |
| mode_q | output | 8 | Register 03h, mode |
| path_q | output | 8 | Register 04h, converter path |
| ramp_q | output | 8 | Register 05h, transition control |
| mute_q | output | 8 | Register 06h, mute control |
| vol_a_q | output | 8 | Register 07h, channel A volume |
| vol_b_q | output | 8 | Register 08h, channel B volume |

## Verification
Two pairs of functions can land in the same cycle. A transaction start can arrive together with the write byte it opens. A data write can arrive together with a read strobe. The bench drives both cases directly. In the first, it checks that the byte became the pointer: the next reads come from the new index and no output changed. In the second, it checks that only the write took effect: the written output changed, and `rd_data` then shows the register exactly one index further on.

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
  parameter logic [7:0] ID_CODE = 8'hC1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_start,
  input  logic       wr_valid,
  input  logic [7:0] wr_byte,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  output logic [7:0] pwr_q,
  output logic [7:0] mode_q,
  output logic [7:0] path_q,
  output logic [7:0] ramp_q,
  output logic [7:0] mute_q,
  output logic [7:0] vol_a_q,
  output logic [7:0] vol_b_q
);
  localparam int FIRST = 2;
  localparam int LAST  = 8;

  function automatic logic [7:0] wmask(int a);
    case (a)
      2:       return 8'hA3;
      3:       return 8'h3F;
      4:       return 8'hF9;
      6:       return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rstval(int a);
    case (a)
      3:       return 8'h30;
      5:       return 8'h60;
      6:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  logic       expect_ptr;
  logic       ptr_inc;
  logic [6:0] ptr_idx;
  logic [7:0] bank [FIRST:LAST];

  wire ptr_load = wr_valid && (txn_start || expect_ptr);
  wire data_wr  = wr_valid && !ptr_load;
  wire data_rd  = rd_strobe && !wr_valid;
  wire step     = ptr_inc && (data_wr || data_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_ptr <= 1'b1;
      ptr_inc    <= 1'b0;
      ptr_idx    <= '0;
    end else begin
      if (ptr_load)       expect_ptr <= 1'b0;
      else if (txn_start) expect_ptr <= 1'b1;
      if (ptr_load)  {ptr_inc, ptr_idx} <= wr_byte;
      else if (step) ptr_idx <= ptr_idx + 7'd1;
    end
  end

  for (genvar a = FIRST; a <= LAST; a++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[a] <= rstval(a);
      else if (data_wr && ptr_idx == 7'(a))
        bank[a] <= wr_byte & wmask(a);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (ptr_idx == 7'd1) rd_data = ID_CODE;
    for (int a = FIRST; a <= LAST; a++)
      if (ptr_idx == 7'(a)) rd_data = bank[a];
  end

  assign pwr_q   = bank[2];
  assign mode_q  = bank[3];
  assign path_q  = bank[4];
  assign ramp_q  = bank[5];
  assign mute_q  = bank[6];
  assign vol_a_q = bank[7];
  assign vol_b_q = bank[8];
endmodule

module ctl_regbank_chk #(
  parameter logic [7:0] ID_CODE = 8'hC1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_start,
  input logic       wr_valid,
  input logic [7:0] wr_byte,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic [7:0] pwr_q,
  input logic [7:0] mode_q,
  input logic [7:0] path_q,
  input logic [7:0] ramp_q,
  input logic [7:0] mute_q,
  input logic [7:0] vol_a_q,
  input logic [7:0] vol_b_q,
  input logic       expect_ptr,
  input logic       ptr_inc,
  input logic [6:0] ptr_idx
);
  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && txn_start) |=> ({ptr_inc, ptr_idx} == $past(wr_byte)));

  // R3
  ptr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !txn_start && (rd_strobe || (wr_valid && !expect_ptr)))
      |=> $stable(ptr_idx));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !txn_start && ((rd_strobe && !wr_valid) || (wr_valid && !expect_ptr)))
      |=> (ptr_idx == $past(ptr_idx) + 7'd1) && ptr_inc);

  // R7
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_idx == 7'd1) |-> (rd_data == ID_CODE));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_q & 8'h5C) == 8'h00) && ((mode_q & 8'hC0) == 8'h00) &&
    ((path_q & 8'h06) == 8'h00) && ((mute_q & 8'hC0) == 8'h00));

  // R11
  outs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable({pwr_q, mode_q, path_q, ramp_q, mute_q, vol_a_q, vol_b_q}));
endmodule

bind ctl_regbank ctl_regbank_chk #(.ID_CODE(ID_CODE)) u_chk (.*);

// File: tb/test_ctl_regbank.sv
`timescale 1ns/1ps
module test_ctl_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 1'b0, wr_valid = 1'b0, rd_strobe = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] rd_data, pwr_q, mode_q, path_q, ramp_q, mute_q, vol_a_q, vol_b_q;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ctl_regbank i_ctl_regbank (.*);

  // {req[3:0], op[1:0], byte[7:0], expect[7:0]}; op 0 start+write, 1 write, 2 read
  localparam logic [21:0] VEC [16] = '{
    {4'd2,  2'd0, 8'h82, 8'h00},  // R2 pointer inc, idx 02h
    {4'd8,  2'd1, 8'hFF, 8'h00},  // R8 02h
    {4'd8,  2'd1, 8'hFF, 8'h00},  // R8 03h
    {4'd2,  2'd0, 8'h82, 8'h00},
    {4'd8,  2'd2, 8'h00, 8'hA3},  // R8
    {4'd8,  2'd2, 8'h00, 8'h3F},  // R8
    {4'd4,  2'd2, 8'h00, 8'h00},  // R4 04h default
    {4'd4,  2'd2, 8'h00, 8'h60},  // R4 05h default
    {4'd3,  2'd0, 8'h07, 8'h00},  // R3 fixed, idx 07h
    {4'd3,  2'd1, 8'h11, 8'h00},
    {4'd3,  2'd1, 8'h22, 8'h00},
    {4'd3,  2'd2, 8'h00, 8'h22},  // R3
    {4'd3,  2'd2, 8'h00, 8'h22},  // R3
    {4'd2,  2'd0, 8'h88, 8'h00},
    {4'd4,  2'd1, 8'h5A, 8'h00},
    {4'd6,  2'd2, 8'h00, 8'h00}   // R6 idx 09h
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(logic st, logic wv, logic [7:0] b, logic rs);
    @(negedge clk);
    txn_start = st; wr_valid = wv; wr_byte = b; rd_strobe = rs;
    @(posedge clk); #1;
    txn_start = 1'b0; wr_valid = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic rd(string req, logic [7:0] exp);
    @(negedge clk); #1;
    chk(req, rd_data, exp);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  function automatic logic [55:0] outs();
    return {pwr_q, mode_q, path_q, ramp_q, mute_q, vol_a_q, vol_b_q};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [55:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", pwr_q, 8'h00);  chk("R1", mode_q, 8'h30); chk("R1", path_q, 8'h00);
    chk("R1", ramp_q, 8'h60); chk("R1", mute_q, 8'h20); chk("R1", vol_a_q, 8'h00);
    chk("R1", vol_b_q, 8'h00); chk("R1", rd_data, 8'h00);

    for (int i = 0; i < 16; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][21:18]);
      case (VEC[i][17:16])
        2'd0: cyc(1'b1, 1'b1, VEC[i][15:8], 1'b0);
        2'd1: cyc(1'b0, 1'b1, VEC[i][15:8], 1'b0);
        default: rd(tag, VEC[i][7:0]);
      endcase
    end
    // R11 outputs after table writes
    chk("R11", pwr_q, 8'hA3); chk("R11", mode_q, 8'h3F);
    chk("R11", vol_a_q, 8'h22); chk("R11", vol_b_q, 8'h5A);

    // R7 ID read and ignored write
    snap = outs();
    cyc(1'b1, 1'b1, 8'h01, 1'b0);
    chk("R2", {8'h00, outs()} == {8'h00, snap} ? 8'h01 : 8'h00, 8'h01);
    cyc(1'b0, 1'b1, 8'h55, 1'b0);
    rd("R7", 8'hC1);
    chk("R7", outs() == snap ? 8'h01 : 8'h00, 8'h01);

    // R7 write to unimplemented index ignored, pointer still steps
    cyc(1'b1, 1'b1, 8'h89, 1'b0);
    cyc(1'b0, 1'b1, 8'hFF, 1'b0);
    chk("R7", outs() == snap ? 8'h01 : 8'h00, 8'h01);
    rd("R6", 8'h00);

    // R5 wrap 7Fh -> 00h -> 01h, flag kept
    cyc(1'b1, 1'b1, 8'hFF, 1'b0);
    rd("R5", 8'h00);
    rd("R5", 8'h00);
    rd("R5", 8'hC1);
    rd("R5", 8'hA3);

    // R10 write and read strobe together
    cyc(1'b1, 1'b1, 8'h84, 1'b0);
    cyc(1'b0, 1'b1, 8'hFF, 1'b1);
    chk("R8", path_q, 8'hF9);
    #1 chk("R10", rd_data, 8'h60);
    cyc(1'b0, 1'b1, 8'hAB, 1'b1);
    chk("R10", ramp_q, 8'hAB);
    #1 chk("R10", rd_data, 8'h20);

    // R9 start with no pointer byte keeps pointer
    cyc(1'b1, 1'b0, 8'h00, 1'b0);
    rd("R9", 8'h20);
    rd("R9", 8'h22);

    // R8 mute reserved bits, R11 timing
    cyc(1'b1, 1'b1, 8'h06, 1'b0);
    @(negedge clk); wr_valid = 1'b1; wr_byte = 8'hFF;
    #1 chk("R11", mute_q, 8'h20);
    @(posedge clk); #1; wr_valid = 1'b0;
    chk("R8", mute_q, 8'h3F);
    rd("R3", 8'h3F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule